// File: doc/BRIEF.md
# Logic Analyzer Trigger Matcher

This block watches a bus of sampled logic channels and raises a one-cycle trigger pulse on the first valid sample that meets a single-stage condition. Four 32-bit configuration words drive the condition. The channel word lists the channels that are wired in. The enable mask picks which of those channels take part. The level-select mask makes each channel a level term or an edge term. The polarity mask sets the sense of each term. All terms must hold together, and at most one channel may be an edge term.

Software sets the configuration words and pulses `arm_i`. The block copies the words into a shadow on that pulse. From then on it checks every sample that comes with `smp_valid_i` high. When the condition holds, it pulses `trig_o` and keeps `triggered_o` set until the next arm. If the configuration asks for more than one edge term, the block sets `cfg_err_o` and does not arm.

Top module: `trig_matcher`

## Requirements
- R1: After the asynchronous reset, `trig_o`, `triggered_o`, `armed_o` and `cfg_err_o` are all 0.
- R2: A high `arm_i` on a clock edge copies the configuration words and clears `triggered_o` and `cfg_err_o`. From the following cycle, `armed_o` is 1 unless R6 applies.
- R3: A channel takes part in the condition only when its bit is set in both the enable mask and the channel word.
- R4: A participating channel whose level-select bit is 1 is a level term. It matches when the sample bit equals its polarity bit: polarity 1 matches high and polarity 0 matches low.
- R5: A participating channel whose level-select bit is 0 is an edge term. It matches on a change from the previous valid sample taken since arming: polarity 0 matches a rise (0 to 1) and polarity 1 matches a fall (1 to 0). The first valid sample after arming never matches an edge term.
- R6: If more than one channel is a participating edge term at arm time, `cfg_err_o` is 1 and `armed_o` stays 0 from the following cycle.
- R7: While armed, a valid sample on which every participating term matches drives `trig_o` high for exactly the next cycle. It also sets `triggered_o` and clears `armed_o`.
- R8: If no channel takes part, the first valid sample after arming fires the trigger.
- R9: `triggered_o` stays 1 and `trig_o` stays 0 until the next arm, whatever samples arrive in between.
- R10: Changes to the configuration words while the block is armed have no effect until the next arm.
- R11: Cycles with `smp_valid_i` low neither fire the trigger nor change the previous sample used for edge terms.
- R12: Only the low NUM_CH bits of each configuration word are used. Higher bits are ignored, including in the edge count of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Copies the configuration and arms the block |
| cfg_chan_i | input | 32 | Channel word: the channels wired in |
| cfg_en_i | input | 32 | Enable mask |
| cfg_lvl_i | input | 32 | Level-select mask (1 = level term, 0 = edge term) |
| cfg_pol_i | input | 32 | Polarity mask (level: 1 = high; edge: 1 = falling) |
| smp_valid_i | input | 1 | The sample on `smp_i` is valid |
| smp_i | input | NUM_CH | Sampled channel values |
| trig_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Sticky flag: the trigger has fired since the last arm |
| armed_o | output | 1 | The block is waiting for a trigger |
| cfg_err_o | output | 1 | The last arm was rejected: more than one edge term |

## Verification
The bench builds the block with NUM_CH=4. At that width, every combination of enable, level-select and polarity masks (4096 configurations) can be armed in turn. Each configuration is then fed a stream of valid samples with changing idle cycles in between. That sweep covers every mix of level and edge terms, both edge senses, the rejection of two or more edge terms, and the empty condition. Directed runs cover the channel word, upper configuration bits, configuration changes while armed, and idle-cycle edges.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned CFG_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2,
    ST_BAD   = 2'd3
  } trig_state_e;
endpackage

// File: rtl/trig_cfg_latch.sv
module trig_cfg_latch
  import trig_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CFG_W-1:0]  chan_i,
  input  logic [CFG_W-1:0]  en_i,
  input  logic [CFG_W-1:0]  lvl_i,
  input  logic [CFG_W-1:0]  pol_i,
  output logic [NUM_CH-1:0] lvl_en_o,
  output logic [NUM_CH-1:0] edge_en_o,
  output logic [NUM_CH-1:0] pol_o,
  output logic              bad_o
);
  localparam int unsigned CNT_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0] part_w, edge_w;
  logic [CNT_W-1:0]  edge_cnt;

  assign part_w = en_i[NUM_CH-1:0] & chan_i[NUM_CH-1:0];
  assign edge_w = part_w & ~lvl_i[NUM_CH-1:0];

  always_comb begin
    edge_cnt = '0;
    for (int i = 0; i < NUM_CH; i++) edge_cnt = edge_cnt + CNT_W'(edge_w[i]);
  end

  assign bad_o = edge_cnt > CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_en_o  <= '0;
      edge_en_o <= '0;
      pol_o     <= '0;
    end else if (load_i) begin
      lvl_en_o  <= part_w & lvl_i[NUM_CH-1:0];
      edge_en_o <= edge_w;
      pol_o     <= pol_i[NUM_CH-1:0];
    end
  end
endmodule

// File: rtl/trig_match.sv
module trig_match #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] lvl_en_i,
  input  logic [NUM_CH-1:0] edge_en_i,
  input  logic [NUM_CH-1:0] pol_i,
  input  logic [NUM_CH-1:0] prev_i,
  input  logic [NUM_CH-1:0] cur_i,
  input  logic              has_prev_i,
  output logic              hit_o
);
  logic [NUM_CH-1:0] ok_w;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic lvl_ok, rise, fall, edge_ok;
    assign lvl_ok  = !lvl_en_i[i] || (cur_i[i] == pol_i[i]);
    assign rise    = !prev_i[i] && cur_i[i];
    assign fall    = prev_i[i] && !cur_i[i];
    assign edge_ok = !edge_en_i[i] || (has_prev_i && (pol_i[i] ? fall : rise));
    assign ok_w[i] = lvl_ok && edge_ok;
  end

  assign hit_o = &ok_w;
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              bad_i,
  input  logic              smp_valid_i,
  input  logic [NUM_CH-1:0] smp_i,
  input  logic              hit_i,
  output logic [NUM_CH-1:0] prev_o,
  output logic              has_prev_o,
  output logic              trig_o,
  output trig_state_e       state_o
);
  trig_state_e state_q, state_d;
  logic        take;

  assign take = (state_q == ST_ARMED) && smp_valid_i && !arm_i;

  always_comb begin
    state_d = state_q;
    if (arm_i)                state_d = bad_i ? ST_BAD : ST_ARMED;
    else if (take && hit_i)   state_d = ST_FIRED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      prev_o     <= '0;
      has_prev_o <= 1'b0;
      trig_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_o  <= take && hit_i;
      if (arm_i) begin
        has_prev_o <= 1'b0;
      end else if (take) begin
        prev_o     <= smp_i;
        has_prev_o <= 1'b1;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
  import trig_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [31:0]       cfg_chan_i,
  input  logic [31:0]       cfg_en_i,
  input  logic [31:0]       cfg_lvl_i,
  input  logic [31:0]       cfg_pol_i,
  input  logic              smp_valid_i,
  input  logic [NUM_CH-1:0] smp_i,
  output logic              trig_o,
  output logic              triggered_o,
  output logic              armed_o,
  output logic              cfg_err_o
);
  logic [NUM_CH-1:0] lvl_en, edge_en, pol, prev;
  logic              bad, has_prev, hit;
  trig_state_e       state;

  trig_cfg_latch #(.NUM_CH(NUM_CH)) u_cfg (
    .clk_i, .rst_ni, .load_i(arm_i),
    .chan_i(cfg_chan_i), .en_i(cfg_en_i), .lvl_i(cfg_lvl_i), .pol_i(cfg_pol_i),
    .lvl_en_o(lvl_en), .edge_en_o(edge_en), .pol_o(pol), .bad_o(bad)
  );

  trig_match #(.NUM_CH(NUM_CH)) u_match (
    .lvl_en_i(lvl_en), .edge_en_i(edge_en), .pol_i(pol),
    .prev_i(prev), .cur_i(smp_i), .has_prev_i(has_prev), .hit_o(hit)
  );

  trig_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk_i, .rst_ni, .arm_i, .bad_i(bad), .smp_valid_i, .smp_i, .hit_i(hit),
    .prev_o(prev), .has_prev_o(has_prev), .trig_o, .state_o(state)
  );

  assign armed_o     = state == ST_ARMED;
  assign triggered_o = state == ST_FIRED;
  assign cfg_err_o   = state == ST_BAD;
endmodule

// File: rtl/trig_matcher_chk.sv
module trig_matcher_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic arm_i,
  input logic smp_valid_i,
  input logic trig_o,
  input logic triggered_o,
  input logic armed_o,
  input logic cfg_err_o
);
  // R7
  a_r7_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  // R7
  a_r7_fire_needs_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_o) |-> $past(armed_o) && $past(smp_valid_i));
  // R9
  a_r9_fire_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> triggered_o && !armed_o);
  // R9
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    triggered_o && !arm_i |=> triggered_o && !trig_o);
  // R2
  a_r2_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !triggered_o && !trig_o && (armed_o != cfg_err_o));
  // R6
  a_r6_err_not_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !armed_o && !trig_o);
  // R11
  a_r11_idle_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !trig_o);
endmodule

bind trig_matcher trig_matcher_chk u_chk (
  .clk_i, .rst_ni, .arm_i, .smp_valid_i, .trig_o, .triggered_o, .armed_o, .cfg_err_o
);

// File: tb/trig_matcher_bench.sv
module trig_matcher_bench;
  localparam int NUM_CH = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              arm = 1'b0;
  logic [31:0]       chan = '0, en = '0, lvl = '0, pol = '0;
  logic              vld = 1'b0;
  logic [NUM_CH-1:0] smp = '0;
  logic              trig, trgd, armed, err;
  int                checks = 0, errors = 0;
  bit                done = 1'b0;

  // model state
  logic [NUM_CH-1:0] m_prev;
  bit                m_hp, m_armed;

  always #10 clk = ~clk;

  trig_matcher #(.NUM_CH(NUM_CH)) u_trig_matcher (
    .clk_i(clk), .rst_ni, .arm_i(arm), .cfg_chan_i(chan), .cfg_en_i(en),
    .cfg_lvl_i(lvl), .cfg_pol_i(pol), .smp_valid_i(vld), .smp_i(smp),
    .trig_o(trig), .triggered_o(trgd), .armed_o(armed), .cfg_err_o(err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int edges(logic [31:0] c, logic [31:0] e, logic [31:0] l);
    int n = 0;
    for (int i = 0; i < NUM_CH; i++) n += (c[i] && e[i] && !l[i]) ? 1 : 0;
    return n;
  endfunction

  function automatic bit exp_hit(logic [31:0] c, logic [31:0] e, logic [31:0] l,
                                 logic [31:0] p, logic [NUM_CH-1:0] pv,
                                 logic [NUM_CH-1:0] cu, bit hp);
    bit ok = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (c[i] && e[i]) begin
        if (l[i]) ok &= (cu[i] == p[i]);
        else if (p[i]) ok &= hp && pv[i] && !cu[i];
        else ok &= hp && !pv[i] && cu[i];
      end
    end
    return ok;
  endfunction

  // drives arm with cfg for one edge; returns at the following negedge
  task automatic do_arm(logic [31:0] c, logic [31:0] e, logic [31:0] l, logic [31:0] p);
    chan = c; en = e; lvl = l; pol = p; arm = 1'b1; vld = 1'b0;
    @(negedge clk);
    arm = 1'b0;
    m_hp = 1'b0;
    m_armed = edges(c, e, l) <= 1;
  endtask

  // one valid sample checked against model using armed cfg (c,e,l,p)
  task automatic feed(string req, logic [NUM_CH-1:0] v, logic [31:0] c,
                      logic [31:0] e, logic [31:0] l, logic [31:0] p);
    bit h;
    bit was_fired = trgd;
    vld = 1'b1; smp = v;
    h = m_armed && exp_hit(c, e, l, p, m_prev, v, m_hp);
    @(negedge clk);
    vld = 1'b0;
    check(req, trig, h);
    check("R9", trgd, was_fired || h);
    if (m_armed) begin m_prev = v; m_hp = 1'b1; end
    if (h) m_armed = 1'b0;
  endtask

  task automatic idle(logic [NUM_CH-1:0] v);
    vld = 1'b0; smp = v;
    @(negedge clk);
    check("R11", trig, 0);
  endtask

  initial begin
    #5_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_prev = '0; m_hp = 1'b0; m_armed = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", {trig, trgd, armed, err}, 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", {trig, trgd, armed, err}, 4'b0000);

    // full sweep over en/lvl/pol, all channels wired (R2..R9)
    for (int k = 0; k < 4096; k++) begin
      logic [31:0] e = k & 15, l = (k >> 4) & 15, p = (k >> 8) & 15;
      do_arm(32'hF, e, l, p);
      check("R6", err, edges(32'hF, e, l) > 1);
      check("R2", armed, edges(32'hF, e, l) <= 1);
      check("R2", trgd, 0);
      for (int j = 0; j < 6; j++) begin
        logic [NUM_CH-1:0] v = NUM_CH'(k * 11 + j * 7 + (k >> 4));
        feed((e == 0) ? "R8" : "R7", v, 32'hF, e, l, p);
        idle(~v);
      end
    end

    // R3: ch1 enabled but not in the channel word
    do_arm(32'h1, 32'h3, 32'h3, 32'h3);
    feed("R3", 4'b0001, 32'h1, 32'h3, 32'h3, 32'h3);
    check("R3", trgd, 1);

    // R4: level low on ch2
    do_arm(32'hF, 32'h4, 32'h4, 32'h0);
    feed("R4", 4'b0100, 32'hF, 32'h4, 32'h4, 32'h0);
    feed("R4", 4'b1011, 32'hF, 32'h4, 32'h4, 32'h0);

    // R12: upper bits would add two edge terms
    do_arm(32'hFFFF_FFFF, 32'h31, 32'h0, 32'h0);
    check("R12", {armed, err}, 2'b10);

    // R10: cfg change while armed ignored
    do_arm(32'hF, 32'h1, 32'h1, 32'h1);
    pol = 32'h0; en = 32'hF; lvl = 32'h0;
    feed("R10", 4'b0001, 32'hF, 32'h1, 32'h1, 32'h1);
    check("R10", trgd, 1);

    // R11: idle toggles do not form an edge; R5 rising on ch0
    do_arm(32'hF, 32'h1, 32'h0, 32'h0);
    feed("R5", 4'b0001, 32'hF, 32'h1, 32'h0, 32'h0);
    check("R5", trig, 0);
    feed("R11", 4'b0000, 32'hF, 32'h1, 32'h0, 32'h0);
    idle(4'b0001); idle(4'b0000);
    feed("R11", 4'b0000, 32'hF, 32'h1, 32'h0, 32'h0);
    check("R11", trgd, 0);
    feed("R5", 4'b0001, 32'hF, 32'h1, 32'h0, 32'h0);
    check("R5", trgd, 1);
    feed("R9", 4'b0000, 32'hF, 32'h1, 32'h0, 32'h0);
    feed("R9", 4'b0001, 32'hF, 32'h1, 32'h0, 32'h0);
    // R2: rearm clears sticky flag
    do_arm(32'hF, 32'h1, 32'h0, 32'h1);
    check("R2", {trgd, armed}, 2'b01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule